// File: doc/BRIEF.md
# Staged Memory Transfer Controller

This block places a single-port word memory behind two staging registers: an address holder and a data holder. A processing unit never reaches the storage array directly. Every access goes through those two registers in a fixed order of one-cycle steps, run by a small sequencer. The step order differs between a read and a write.

A requester presents a request pulse while `req_ready` is high. The pulse carries the direction, an address and, for a write, a data word. A read loads the address holder, then pulses the array's read strobe, which loads the data holder from the array. A write loads the data holder first, then the address holder, then pulses the array's write strobe. Either access ends with a one-cycle `done` pulse. After a read, `rd_data` presents the fetched word and keeps it until the next access.

The default configuration has 8 address bits and 16-bit words, which gives 256 locations.

Top module: `mem_xfer_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the sequencer returns to idle and both staging registers clear. After that edge, `req_ready`=1, `busy`=0, `done`=0 and `rd_data`=0.
- R2: A request is accepted only at an edge where `req_ready` is high. While an access is in progress, `req_ready` is 0 and `busy` is 1. A request presented then changes no memory location and does not alter the access in progress.
- R3: A read (`req_write`=0) accepted at edge E makes `done` high in the cycle after edge E+1. In that cycle, `rd_data` equals the word last written to `req_addr`.
- R4: A write (`req_write`=1) accepted at edge E makes `done` high in the cycle after edge E+2. A later read of that address returns `req_wdata`.
- R5: A write stages its data first, then its address one cycle later, then pulses the write strobe one cycle after that. The address and data are captured at acceptance, so the request inputs may change once the write is accepted.
- R6: `done` is high for exactly one cycle. In the following cycle, `req_ready` is 1 again.
- R7: Reset leaves the stored words unchanged, so a read after reset returns the value written before it.
- R8: While idle with no request, `rd_data` holds its value, whatever happens on `req_addr` and `req_wdata`.
- R9: Each of the 2^ADDR_W locations is independent. A write to one address changes no other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Word to write |
| req_ready | output | 1 | Controller idle; a request is accepted at the next edge |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Contents of the data holder; the fetched word after a read |

## Verification
Inputs are driven and outputs sampled on the falling edge. Latency is counted in falling edges after the edge that accepted the request. `done` is due on the second falling edge for a read and on the third for a write, and the bench compares the measured count exactly. The returned word is taken in the `done` cycle. `done` low and `req_ready` high are checked on the next falling edge. The hold-off case drives a competing request on every busy falling edge and releases it at the `done` edge. It then reads back both the target address and the intruder's address. The stability check waits several idle falling edges before comparing `rd_data`.

// File: rtl/mxc_pkg.sv
// Package: shared types for the staged memory transfer controller.
// Assumes: nothing beyond IEEE 1800-2017.
package mxc_pkg;

    // Sequencer steps; one clock cycle each.
    typedef enum logic [2:0] {
        XS_IDLE   = 3'd0,
        XS_RD_STB = 3'd1,
        XS_WR_ADR = 3'd2,
        XS_WR_STB = 3'd3,
        XS_FINISH = 3'd4
    } xfer_state_e;

endpackage

// File: rtl/mxc_sequencer.sv
// Module: mxc_sequencer
// Steps one access through its staging loads and memory strobe.
// A read goes address, then read strobe. A write goes data, then address,
// then write strobe. Each access ends with a one-cycle finish state.
// Assumes: synchronous active-low reset; requests are seen only when idle.
module mxc_sequencer (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic mar_ld,
    output logic mar_from_hold,
    output logic mdr_ld_req,
    output logic rd_stb,
    output logic wr_stb,
    output logic ready,
    output logic fin
);
    import mxc_pkg::*;

    xfer_state_e state_q, state_d;
    logic        accept;

    // Acceptance happens only in the idle state.
    assign accept = (state_q == XS_IDLE) && req_valid;

    // Next-state selection for the step order.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE:   if (req_valid) state_d = req_write ? XS_WR_ADR : XS_RD_STB;
            XS_RD_STB: state_d = XS_FINISH;
            XS_WR_ADR: state_d = XS_WR_STB;
            XS_WR_STB: state_d = XS_FINISH;
            XS_FINISH: state_d = XS_IDLE;
            default:   state_d = XS_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Control strobes decoded from the current step.
    always_comb begin
        mar_ld        = (accept && !req_write) || (state_q == XS_WR_ADR);
        mar_from_hold = (state_q == XS_WR_ADR);
        mdr_ld_req    = accept && req_write;
        rd_stb        = (state_q == XS_RD_STB);
        wr_stb        = (state_q == XS_WR_STB);
        ready         = (state_q == XS_IDLE);
        fin           = (state_q == XS_FINISH);
    end

    // R2
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);
    // R3
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && !req_write) |=> !fin ##1 fin);
    // R4
    write_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_write) |=> !fin ##1 !fin ##1 fin);
    // R6
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (!fin && ready));
endmodule

// File: rtl/mxc_stage_regs.sv
// Module: mxc_stage_regs
// Holds the address holder, the data holder and the held write address.
// The data holder loads from the request on write acceptance and from the
// array on a read strobe.
// Assumes: the control strobes come from mxc_sequencer and are mutually
// consistent.
module mxc_stage_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mar_ld,
    input  logic              mar_from_hold,
    input  logic              mdr_ld_req,
    input  logic              rd_stb,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q
);
    logic [ADDR_W-1:0] hold_addr_q;

    // Address holder: loads from the request (read) or the held address (write).
    always_ff @(posedge clk) begin
        if (!rst_n)      mar_q <= '0;
        else if (mar_ld) mar_q <= mar_from_hold ? hold_addr_q : req_addr;
    end

    // Data holder and held write address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q       <= '0;
            hold_addr_q <= '0;
        end else if (mdr_ld_req) begin
            mdr_q       <= req_wdata;
            hold_addr_q <= req_addr;
        end else if (rd_stb) begin
            mdr_q       <= mem_rdata;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (mar_q == '0 && mdr_q == '0));
endmodule

// File: rtl/mxc_word_array.sv
// Module: mxc_word_array
// Behavioural single-port word storage. The write is synchronous on the
// strobe. The read is combinational from the address holder and is
// captured by the data holder.
// Assumes: contents are not reset; DEPTH = 2^ADDR_W.
module mxc_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Word write on the write strobe.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // Asynchronous read of the addressed word.
    assign rdata = cells[addr];
endmodule

// File: rtl/mem_xfer_ctrl.sv
// Module: mem_xfer_ctrl (top)
// Memory access controller that reaches its word array only through the
// address and data staging registers.
// Assumes: one request at a time; requests made while busy are ignored.
module mem_xfer_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    logic              mar_ld, mar_from_hold, mdr_ld_req, rd_stb, wr_stb;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mdr_q, mem_rdata;

    mxc_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .mar_ld(mar_ld), .mar_from_hold(mar_from_hold), .mdr_ld_req(mdr_ld_req),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .ready(req_ready), .fin(done)
    );

    mxc_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_rdata(mem_rdata), .mar_ld(mar_ld), .mar_from_hold(mar_from_hold),
        .mdr_ld_req(mdr_ld_req), .rd_stb(rd_stb), .mar_q(mar_q), .mdr_q(mdr_q)
    );

    mxc_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(wr_stb), .addr(mar_q), .wdata(mdr_q), .rdata(mem_rdata)
    );

    // Port outputs.
    assign busy    = !req_ready;
    assign rd_data = mdr_q;

    // R5
    write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(mar_ld) && $past(mdr_ld_req, 2)));
    // R3
    read_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(mar_ld));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(rd_data));
endmodule

// File: tb/mem_xfer_ctrl_test.sv
// Bench for mem_xfer_ctrl: exhaustive write/read sweep with computed words,
// hold-off, reset-retention and idle-stability cases.
module mem_xfer_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, busy, done;
    logic [DW-1:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] last_rd;
    logic [DW-1:0] hold_val;

    mem_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pattern(input int a, input int salt);
        return DW'((a * 40503 + salt * 7919) ^ 16'h5A5A);
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One access; optionally drives a competing write while busy.
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic intrude, input logic [AW-1:0] ia,
                          input logic [DW-1:0] id, input string tag);
        int lat;
        int exp_lat;
        exp_lat = wr ? 3 : 2;
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " ready before request"}, req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (done) begin
                req_valid = 1'b0;
            end else if (intrude) begin
                // R2: held off while busy
                chk(req_ready == 1'b0 && busy == 1'b1, "R2 hold-off while busy", req_ready, 0);
                req_valid = 1'b1; req_write = 1'b1; req_addr = ia; req_wdata = id;
            end else begin
                req_valid = 1'b0;
            end
        end while (!done && lat < 20);
        req_valid = 1'b0;
        last_rd = rd_data;
        chk(lat == exp_lat, wr ? "R4 write latency" : "R3 read latency", lat, exp_lat);
        if (wr) model[a] = d;
        @(negedge clk);
        // R6: single-cycle done, ready again
        chk(done == 1'b0 && req_ready == 1'b1, "R6 done pulse and ready", {done, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(req_ready == 1 && busy == 0 && done == 0 && rd_data == 0,
            "R1 reset state", {req_ready, busy, done, rd_data}, {3'b100, 16'h0});

        // R9 / R4: write every location with a computed word
        for (int a = 0; a < DEPTH; a++)
            access(1'b1, AW'(a), pattern(a, 1), 1'b0, '0, '0, "R4 sweep");
        // R9 / R3: read every location back
        for (int a = 0; a < DEPTH; a++) begin
            access(1'b0, AW'(a), '0, 1'b0, '0, '0, "R3 sweep");
            chk(last_rd == model[a], "R9 read-back per address", last_rd, model[a]);
        end

        // R2: read while a write competes; the intruder's address stays untouched
        access(1'b0, 8'd5, '0, 1'b1, 8'd6, 16'hDEAD, "R2 read intruded");
        chk(last_rd == model[5], "R2 read unaffected", last_rd, model[5]);
        access(1'b0, 8'd6, '0, 1'b0, '0, '0, "R2 check");
        chk(last_rd == model[6], "R2 intruder ignored", last_rd, model[6]);

        // R5: write with inputs changing after acceptance
        access(1'b1, 8'd7, 16'h1234, 1'b1, 8'd8, 16'hBEEF, "R5 write intruded");
        access(1'b0, 8'd7, '0, 1'b0, '0, '0, "R5 check");
        chk(last_rd == 16'h1234, "R5 held address and data", last_rd, 16'h1234);
        access(1'b0, 8'd8, '0, 1'b0, '0, '0, "R5 check");
        chk(last_rd == model[8], "R5 other address untouched", last_rd, model[8]);

        // R8: idle stability while request fields move
        access(1'b0, 8'd200, '0, 1'b0, '0, '0, "R8 setup");
        hold_val = rd_data;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            req_addr = AW'(i * 37); req_wdata = DW'(i * 4099);
        end
        @(negedge clk);
        chk(rd_data == hold_val, "R8 rd_data stable when idle", rd_data, hold_val);

        // R9: boundary addresses after edits
        access(1'b1, '1, 16'hFFFF, 1'b0, '0, '0, "R9 top");
        access(1'b1, '0, 16'h0001, 1'b0, '0, '0, "R9 bottom");
        access(1'b0, 8'd1, '0, 1'b0, '0, '0, "R9 check");
        chk(last_rd == model[1], "R9 neighbour of 0 untouched", last_rd, model[1]);
        access(1'b0, '1, '0, 1'b0, '0, '0, "R9 check");
        chk(last_rd == 16'hFFFF, "R9 top address", last_rd, 16'hFFFF);

        // R7 / R1: reset clears staging but keeps contents
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(rd_data == 0 && req_ready == 1, "R1 reset clears data holder", rd_data, 0);
        access(1'b0, 8'd7, '0, 1'b0, '0, '0, "R7 check");
        chk(last_rd == 16'h1234, "R7 contents survive reset", last_rd, 16'h1234);

        // R3: back-to-back write then read of one address
        access(1'b1, 8'd99, 16'hA5C3, 1'b0, '0, '0, "R4 b2b");
        access(1'b0, 8'd99, '0, 1'b0, '0, '0, "R3 b2b");
        chk(last_rd == 16'hA5C3, "R3 read after write", last_rd, 16'hA5C3);

        finish_run();
    end
endmodule